// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital side of an eight-input, 12-bit successive-approximation converter that hangs on a parallel processor bus. A host starts a conversion by pulling chip select and write low together. That same strobe captures the three-bit input address and blanks the data bus. The block then runs a short sampling window, performs one binary-search trial per result bit, and publishes the finished code. While it works, it holds an active-low busy flag low. The analog parts sit outside the block and meet it only at ports: the input selector is driven from `chan_o`, the capacitor array from `dac_o`, the sampling switch from `sample_o`, and the comparator decision arrives on `cmp_i`.

Half-clock timing is built from a tick clock `clk2x_i` that runs at twice the conversion clock. One conversion clock is therefore two ticks. Sampling takes 3 ticks (1.5 conversion clocks) and the conversion proper takes 27 ticks (13.5 conversion clocks). The whole busy window fits inside a 16-clock frame. The host reads the result by pulling chip select and read low together.

Top module: `sarc_ctrl`

## Requirements
- R1: When the block is idle, a tick edge that first sees cs_ni and wr_ni both low starts a conversion, and busy_no is low after that edge.
- R2: The input address is captured from addr_i at the start edge as plain binary (value k selects input k, 0 to 7) and drives chan_o unchanged until the next accepted start.
- R3: busy_no stays low for exactly 30 ticks (15 conversion clocks) and then returns high.
- R4: sample_o is high for exactly the first 3 ticks of the busy window and low at all other times.
- R5: Trials run MSB first, two ticks per bit, beginning at tick 3. Each trial sets its bit in dac_o. At the trial's second edge the bit is cleared if cmp_i is 1 (array above input), and the next lower bit is set. dac_o is 0 during sampling.
- R6: The result is 12-bit straight binary with db_o[11] as MSB. It is updated only on the last trial and holds at every other time.
- R7: db_oe_o is high, and db_o carries the result, only while cs_ni and rd_ni are both low and no conversion is pending.
- R8: Starting a conversion blanks the bus, so db_oe_o stays low from the start edge until busy_no rises, even with cs_ni and rd_ni low.
- R9: A start strobe that arrives while busy_no is low is ignored. The running conversion keeps its input and timing.
- R10: A strobe held low does not retrigger. A new conversion needs cs_ni/wr_ni to be released and asserted again.
- R11: After reset, busy_no is 1, sample_o is 0, chan_o is 0, dac_o is 0, the result is 0 and the bus is readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Tick clock, twice the conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low; starts a conversion with cs_ni |
| rd_ni | input | 1 | Read strobe, active low |
| addr_i | input | 3 | Input address, plain binary |
| cmp_i | input | 1 | Comparator decision, 1 when the array output is above the input |
| busy_no | output | 1 | Low while a conversion runs |
| sample_o | output | 1 | High during the sampling window |
| chan_o | output | 3 | Captured input address for the analog selector |
| dac_o | output | 12 | Trial code for the capacitor array |
| db_o | output | 12 | Three-state result bus |
| db_oe_o | output | 1 | High while db_o is driven |

## Verification
The bench drives the comparator from a table of per-input levels that includes zero, full scale and the mid-scale pair 2047/2048. A design that clears the wrong bit, or tests in the wrong order, misses those exact codes. A second start issued during a conversion, with a different address, catches designs that restart or swap the input mid-way: the busy width or the result would be wrong. A strobe held across the end of a conversion exposes a level-triggered start, which would produce a second busy window. A read attempted during a conversion catches a bus that leaks the stale result.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACQ  = 2'd1,
        PH_CONV = 2'd2,
        PH_TAIL = 2'd3
    } sarc_phase_e;

endpackage

// File: rtl/sarc_strobe.sv
module sarc_strobe (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_ni,
    input  logic wr_ni,
    output logic start_o
);

    typedef struct packed {
        logic armed;
    } strobe_st_t;

    strobe_st_t s_d, s_q;
    logic       strobe;

    assign strobe  = ~cs_ni & ~wr_ni;
    assign start_o = strobe & ~s_q.armed;

    always_comb begin
        s_d       = s_q;
        s_d.armed = strobe;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R10: two starts in a row need a released strobe between them
    assert_no_retrigger_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);

endmodule

// File: rtl/sarc_seq.sv
module sarc_seq
    import sarc_pkg::*;
#(
    parameter int NBITS      = 12,
    parameter int NCH        = 8,
    parameter int ACQ_HALF   = 3,
    parameter int TRIAL_HALF = 2,
    parameter int TAIL_HALF  = 3
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     start_i,
    input  logic [$clog2(NCH)-1:0]   addr_i,
    input  logic                     cmp_i,
    output logic                     busy_no,
    output logic                     sample_o,
    output logic [$clog2(NCH)-1:0]   chan_o,
    output logic [NBITS-1:0]         code_o,
    output logic [NBITS-1:0]         result_o,
    output logic                     pend_o
);

    localparam int AW        = $clog2(NCH);
    localparam int BW        = $clog2(NBITS);
    localparam int MAXH      = (ACQ_HALF > TRIAL_HALF) ?
                               ((ACQ_HALF > TAIL_HALF) ? ACQ_HALF : TAIL_HALF) :
                               ((TRIAL_HALF > TAIL_HALF) ? TRIAL_HALF : TAIL_HALF);
    localparam int CW        = $clog2(MAXH + 1);
    localparam int BUSY_HALF = ACQ_HALF + NBITS * TRIAL_HALF + TAIL_HALF;
    localparam int LW        = $clog2(BUSY_HALF + 2);

    typedef struct packed {
        sarc_phase_e       phase;
        logic [CW-1:0]     cnt;
        logic [BW-1:0]     bidx;
        logic [NBITS-1:0]  code;
        logic [NBITS-1:0]  result;
        logic [AW-1:0]     chan;
        logic              pend;
    } seq_st_t;

    seq_st_t          s_d, s_q;
    logic [NBITS-1:0] trial;
    logic [BW-1:0]    nbit;

    always_comb begin
        s_d   = s_q;
        trial = s_q.code;
        nbit  = s_q.bidx - BW'(1);
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase = PH_ACQ;
                    s_d.cnt   = '0;
                    s_d.chan  = addr_i;
                    s_d.code  = '0;
                    s_d.pend  = 1'b1;
                end
            end
            PH_ACQ: begin
                if (s_q.cnt == CW'(ACQ_HALF - 1)) begin
                    s_d.phase = PH_CONV;
                    s_d.cnt   = '0;
                    s_d.bidx  = BW'(NBITS - 1);
                    s_d.code  = {1'b1, {(NBITS-1){1'b0}}};
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            PH_CONV: begin
                if (s_q.cnt == CW'(TRIAL_HALF - 1)) begin
                    s_d.cnt = '0;
                    if (cmp_i) trial[s_q.bidx] = 1'b0;
                    if (s_q.bidx == '0) begin
                        s_d.code   = trial;
                        s_d.result = trial;
                        s_d.phase  = PH_TAIL;
                    end else begin
                        trial[nbit] = 1'b1;
                        s_d.code    = trial;
                        s_d.bidx    = nbit;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            PH_TAIL: begin
                if (s_q.cnt == CW'(TAIL_HALF - 1)) begin
                    s_d.phase = PH_IDLE;
                    s_d.cnt   = '0;
                    s_d.pend  = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            default: s_d = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign busy_no  = (s_q.phase == PH_IDLE);
    assign sample_o = (s_q.phase == PH_ACQ);
    assign chan_o   = s_q.chan;
    assign code_o   = s_q.code;
    assign result_o = s_q.result;
    assign pend_o   = s_q.pend;

    // busy-window length tracker for the width check
    logic [LW-1:0] blen_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 blen_q <= '0;
        else if (s_q.phase != PH_IDLE) blen_q <= blen_q + LW'(1);
        else                         blen_q <= '0;
    end

    assert_busy_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_no) |-> (blen_q == LW'(BUSY_HALF)));

    assert_start_drops_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && busy_no) |=> !busy_no);

    assert_chan_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_no |=> $stable(chan_o));

    assert_result_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.phase != PH_CONV) |=> $stable(result_o));

    assert_sample_only_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |-> !busy_no);

endmodule

// File: rtl/sarc_bus.sv
module sarc_bus #(
    parameter int NBITS = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cs_ni,
    input  logic             rd_ni,
    input  logic             pend_i,
    input  logic [NBITS-1:0] result_i,
    output logic             oe_o,
    output logic [NBITS-1:0] db_o
);

    assign oe_o = ~cs_ni & ~rd_ni & ~pend_i;

    for (genvar b = 0; b < NBITS; b++) begin : g_drv
        assign db_o[b] = oe_o ? result_i[b] : 1'bz;
    end

    assert_oe_needs_select_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oe_o |-> (!cs_ni && !rd_ni));

    assert_blank_while_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_i |-> !oe_o);

endmodule

// File: rtl/sarc_ctrl.sv
module sarc_ctrl #(
    parameter int NBITS      = 12,
    parameter int NCH        = 8,
    parameter int ACQ_HALF   = 3,
    parameter int TRIAL_HALF = 2,
    parameter int TAIL_HALF  = 3
) (
    input  logic                   clk2x_i,
    input  logic                   rst_ni,
    input  logic                   cs_ni,
    input  logic                   wr_ni,
    input  logic                   rd_ni,
    input  logic [$clog2(NCH)-1:0] addr_i,
    input  logic                   cmp_i,
    output logic                   busy_no,
    output logic                   sample_o,
    output logic [$clog2(NCH)-1:0] chan_o,
    output logic [NBITS-1:0]       dac_o,
    output logic [NBITS-1:0]       db_o,
    output logic                   db_oe_o
);

    logic             start;
    logic             pend;
    logic [NBITS-1:0] result;

    sarc_strobe u_strobe (
        .clk_i   (clk2x_i),
        .rst_ni  (rst_ni),
        .cs_ni   (cs_ni),
        .wr_ni   (wr_ni),
        .start_o (start)
    );

    sarc_seq #(
        .NBITS      (NBITS),
        .NCH        (NCH),
        .ACQ_HALF   (ACQ_HALF),
        .TRIAL_HALF (TRIAL_HALF),
        .TAIL_HALF  (TAIL_HALF)
    ) u_seq (
        .clk_i    (clk2x_i),
        .rst_ni   (rst_ni),
        .start_i  (start),
        .addr_i   (addr_i),
        .cmp_i    (cmp_i),
        .busy_no  (busy_no),
        .sample_o (sample_o),
        .chan_o   (chan_o),
        .code_o   (dac_o),
        .result_o (result),
        .pend_o   (pend)
    );

    sarc_bus #(
        .NBITS (NBITS)
    ) u_bus (
        .clk_i    (clk2x_i),
        .rst_ni   (rst_ni),
        .cs_ni    (cs_ni),
        .rd_ni    (rd_ni),
        .pend_i   (pend),
        .result_i (result),
        .oe_o     (db_oe_o),
        .db_o     (db_o)
    );

endmodule

// File: tb/sarc_ctrl_test.sv
`timescale 1ns/1ps
module sarc_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [2:0]  addr = '0;
    logic        cmp;
    logic        busy_n, sample;
    logic [2:0]  chan;
    logic [11:0] dac, db;
    logic        oe;

    int vectors = 0;
    int misses  = 0;
    int ticks   = 0;
    int busy_falls = 0;
    logic busy_prev = 1'b1;

    logic [11:0] vin [8];

    always #2.5 clk = ~clk;

    sarc_ctrl uut (
        .clk2x_i (clk), .rst_ni (rst_n), .cs_ni (cs_n), .wr_ni (wr_n),
        .rd_ni (rd_n), .addr_i (addr), .cmp_i (cmp), .busy_no (busy_n),
        .sample_o (sample), .chan_o (chan), .dac_o (dac), .db_o (db),
        .db_oe_o (oe)
    );

    // behavioural comparator: array above the selected input level
    assign cmp = (dac > vin[chan]);

    // reference model, stepped once per tick
    int          t = -1;
    int          m_bit = 0;
    logic [11:0] m_code = '0, m_res = '0;
    logic [2:0]  m_ch = '0;
    logic        m_hiz = 1'b0, m_prev = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t = -1; m_code = '0; m_res = '0; m_ch = '0; m_hiz = 1'b0; m_prev = 1'b0;
        end else begin
            logic strobe, edge_seen;
            strobe    = !cs_n && !wr_n;
            edge_seen = strobe && !m_prev;
            m_prev    = strobe;
            if (t < 0) begin
                if (edge_seen) begin
                    t = 0; m_ch = addr; m_hiz = 1'b1; m_code = '0;
                end
            end else begin
                t = t + 1;
                if (t == 3) begin
                    m_code = 12'h800; m_bit = 11;
                end else if (t >= 5 && t <= 27 && ((t - 5) % 2 == 0)) begin
                    if (m_code > vin[m_ch]) m_code[m_bit] = 1'b0;
                    if (m_bit == 0) m_res = m_code;
                    else begin
                        m_bit = m_bit - 1;
                        m_code[m_bit] = 1'b1;
                    end
                end
                if (t == 30) begin
                    t = -1; m_hiz = 1'b0;
                end
            end
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-tick comparison against the model, away from the active edge
    always @(negedge clk) begin
        ticks++;
        if (!busy_n && busy_prev) busy_falls++;
        busy_prev = busy_n;
        check(busy_n === (t < 0), "R3 busy_no", busy_n, t < 0);
        check(sample === (t >= 0 && t <= 2), "R4 sample_o", sample, t >= 0 && t <= 2);
        check(chan === m_ch, "R2 chan_o", chan, m_ch);
        check(dac === m_code, "R5 dac_o", dac, m_code);
        check(oe === (!cs_n && !rd_n && !m_hiz), "R7 db_oe_o", oe, !cs_n && !rd_n && !m_hiz);
        if (oe) check(db === m_res, "R6 db_o", db, m_res);
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input logic [2:0] a);
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; addr = a;
        @(negedge clk); #0.1;
        check(busy_n === 1'b0, "R1 start edge", busy_n, 0);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic read_expect(input logic [11:0] exp, input string tag);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        #0.1;
        check(oe === 1'b1, tag, oe, 1);
        check(db === exp, tag, db, exp);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    endtask

    initial begin
        vin[0] = 12'd0;    vin[1] = 12'd4095; vin[2] = 12'd2048; vin[3] = 12'd2047;
        vin[4] = 12'd1;    vin[5] = 12'hAAA;  vin[6] = 12'h555;  vin[7] = 12'd3001;
        tick(3);
        #0.1;
        check(busy_n === 1'b1 && sample === 1'b0 && chan === 3'd0 && dac === 12'd0,
              "R11 reset outputs", {busy_n, sample, chan, dac}, 17'h10000);
        @(negedge clk); rst_n = 1'b1;
        read_expect(12'd0, "R11 reset result");

        // each input in turn, address as plain binary
        for (int k = 0; k < 8; k++) begin
            start(3'(k));
            check(chan === 3'(k), "R2 captured address", chan, k);
            tick(32);
            read_expect(vin[k], "R6 final code");
        end

        // read during a conversion stays blank
        start(3'd5);
        tick(8); cs_n = 1'b0; rd_n = 1'b0;
        #0.1; check(oe === 1'b0, "R8 blank during conversion", oe, 0);
        tick(4); cs_n = 1'b1; rd_n = 1'b1;
        tick(24);
        read_expect(vin[5], "R8 result after conversion");

        // second strobe while busy, other address
        start(3'd1);
        tick(6); cs_n = 1'b0; wr_n = 1'b0; addr = 3'd6;
        tick(2); cs_n = 1'b1; wr_n = 1'b1;
        #0.1; check(chan === 3'd1, "R9 input kept", chan, 1);
        tick(26);
        read_expect(vin[1], "R9 result unchanged");

        // strobe held across the end of a conversion
        busy_falls = 0;
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; addr = 3'd3;
        tick(70);
        cs_n = 1'b1; wr_n = 1'b1;
        tick(2);
        check(busy_falls == 1, "R10 single conversion", busy_falls, 1);
        read_expect(vin[3], "R10 result");

        // back-to-back starts
        start(3'd2);
        while (!busy_n) @(negedge clk);
        start(3'd7);
        tick(32);
        read_expect(vin[7], "R2 back-to-back");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        misses++;
        vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule